// File: doc/BRIEF.md
# Bit-Serial CRC Remainder Unit

This block divides a serial bit stream by a fixed generator polynomial using modulo-2 arithmetic, where addition is XOR and no carries occur. The division is done one bit per valid cycle in a feedback shift register. The polynomial degree and its lower coefficients are parameters. The leading coefficient is implied.

On the sending side, message bits enter most significant first with the emit select low. The register then holds the remainder of the message multiplied by x^DEG, which is the same as the message with DEG zero bits appended, so the zeros never have to be clocked in. Raising emit then shifts that remainder out of the serial output, most significant bit first, with zero fill and the feedback cut. The message followed by those bits is a codeword.

On the receiving side, the same circuit takes in the whole codeword with emit low. The zero flag then shows whether the division left nothing over. A synchronous clear starts a new frame.

Top module: `crc_serial`

## Requirements
- R1: After the asynchronous reset is released, the remainder register is all zeros, so `check_ok` is 1 and `bit_out` is 0.
- R2: With `emit`=0, each cycle with `bit_vld`=1 takes in `bit_in` as the next dividend bit, most significant first. After a message has been taken in, the register holds the message times x^DEG modulo the generator. For x^3+x+1, message 1101 gives 001. For x^4+x^2+1, message 00111011001 gives 1101.
- R3: With `emit`=1, each cycle with `bit_vld`=1 shifts the register one place toward its MSB with a zero entering at the LSB, and no feedback is applied. `bit_out` therefore presents the remainder MSB first, and after DEG such cycles the register is zero.
- R4: A codeword, meaning a message followed by its DEG-bit remainder, taken in from a cleared register with `emit`=0 leaves `check_ok`=1.
- R5: A codeword with any one bit inverted leaves `check_ok`=0.
- R6: A codeword with an error burst no longer than DEG bits leaves `check_ok`=0. The burst length is counted from its first inverted bit to its last inverted bit, and both of those bits are inverted.
- R7: In a cycle with `bit_vld`=0 and `clr`=0, the register keeps its value whatever `bit_in` and `emit` are.
- R8: `clr`=1 zeroes the register on the next clock edge and takes priority over `bit_vld`.
- R9: `bit_out` always equals the register MSB. `check_ok` is 1 exactly when the whole register is zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous reset, active low |
| clr | input | 1 | Synchronous clear of the remainder register |
| emit | input | 1 | 0: divide (take in bits), 1: shift the remainder out |
| bit_in | input | 1 | Serial dividend bit |
| bit_vld | input | 1 | Advances the register by one bit |
| bit_out | output | 1 | Serial remainder bit (register MSB) |
| check_ok | output | 1 | High when the register is all zeros |

## Verification
The bench builds three copies side by side, fed from the same inputs.

The degree-3 copy uses x^3+x+1. Its codewords are short enough to walk a table of messages and to flip every codeword position in turn.

The degree-4 copy uses x^4+x^2+1. It reproduces a longer worked division with a known answer.

The degree-16 copy uses x^16+x^12+x^5+1. It brings bursts of every length from 2 to 16 within reach at several offsets inside a 48-bit codeword, which the short polynomials cannot reach.

// File: rtl/crc_serial.sv
module crc_serial #(
  parameter int DEG = 3,
  parameter logic [DEG-1:0] POLY = 'h3
) (
  input  logic clk,
  input  logic rst_n,
  input  logic clr,
  input  logic emit,
  input  logic bit_in,
  input  logic bit_vld,
  output logic bit_out,
  output logic check_ok
);

  logic [DEG-1:0] rem;
  logic           fb;
  logic [DEG-1:0] shl;

  assign fb  = bit_in ^ rem[DEG-1];
  assign shl = {rem[DEG-2:0], 1'b0};

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)       rem <= '0;
    else if (clr)     rem <= '0;
    else if (bit_vld) rem <= emit ? shl : (shl ^ (fb ? POLY : '0));
  end

  assign bit_out  = rem[DEG-1];
  assign check_ok = ~|rem;

endmodule

// File: rtl/crc_serial_chk.sv
module crc_serial_chk #(
  parameter int DEG = 3
) (
  input logic           clk,
  input logic           rst_n,
  input logic           clr,
  input logic           emit,
  input logic           bit_in,
  input logic           bit_vld,
  input logic           bit_out,
  input logic           check_ok,
  input logic [DEG-1:0] rem
);

  assert_clear_zero_R8: assert property (@(posedge clk) disable iff (!rst_n)
    clr |=> (check_ok && !bit_out));

  assert_idle_hold_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (!clr && !bit_vld) |=> $stable(rem));

  assert_emit_shift_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (!clr && bit_vld && emit) |=> (bit_out == $past(rem[DEG-2])));

  assert_zero_msb_R9: assert property (@(posedge clk) disable iff (!rst_n)
    check_ok |-> !bit_out);

  assert_zero_stays_R2: assert property (@(posedge clk) disable iff (!rst_n)
    (!clr && bit_vld && !emit && !bit_in && check_ok) |=> check_ok);

endmodule

bind crc_serial crc_serial_chk #(.DEG(DEG)) u_chk (
  .clk(clk), .rst_n(rst_n), .clr(clr), .emit(emit), .bit_in(bit_in),
  .bit_vld(bit_vld), .bit_out(bit_out), .check_ok(check_ok), .rem(rem)
);

// File: tb/crc_serial_tb.sv
module crc_serial_tb;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic clr = 1'b0, emit = 1'b0, bit_in = 1'b0, bit_vld = 1'b0;
  logic bo3, ok3, bo4, ok4, bo16, ok16;
  int   n_run = 0, n_fail = 0;
  logic done = 1'b0;

  always #2 clk = ~clk;

  crc_serial #(.DEG(3), .POLY(3'b011)) u_dut (
    .clk(clk), .rst_n(rst_n), .clr(clr), .emit(emit), .bit_in(bit_in),
    .bit_vld(bit_vld), .bit_out(bo3), .check_ok(ok3));

  crc_serial #(.DEG(4), .POLY(4'b0101)) u_dut4 (
    .clk(clk), .rst_n(rst_n), .clr(clr), .emit(emit), .bit_in(bit_in),
    .bit_vld(bit_vld), .bit_out(bo4), .check_ok(ok4));

  crc_serial #(.DEG(16), .POLY(16'h1021)) u_dut16 (
    .clk(clk), .rst_n(rst_n), .clr(clr), .emit(emit), .bit_in(bit_in),
    .bit_vld(bit_vld), .bit_out(bo16), .check_ok(ok16));

  // {message[3:0], remainder[2:0]} for x^3+x+1
  localparam logic [6:0] VEC [7] = '{
    7'b0000_000, 7'b0001_011, 7'b1000_101, 7'b1101_001,
    7'b1111_111, 7'b0110_001, 7'b1010_011
  };

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    n_run++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic step(input logic b, input logic em, input logic v, input logic c);
    @(negedge clk);
    bit_in = b; emit = em; bit_vld = v; clr = c;
    @(posedge clk);
    #1;
  endtask

  task automatic idle();
    step(1'b0, 1'b0, 1'b0, 1'b0);
  endtask

  task automatic clear();
    step(1'b0, 1'b0, 1'b0, 1'b1);
    idle();
  endtask

  task automatic shift_bits(input logic [63:0] v, input int n);
    for (int k = n - 1; k >= 0; k--) step(v[k], 1'b0, 1'b1, 1'b0);
    idle();
  endtask

  task automatic emit_bits(input int n, input int which, output logic [31:0] got);
    got = '0;
    for (int k = 0; k < n; k++) begin
      got = {got[30:0], (which == 3) ? bo3 : (which == 4) ? bo4 : bo16};
      step(1'b0, 1'b1, 1'b1, 1'b0);
    end
    idle();
  endtask

  logic [31:0] got;
  logic [47:0] cw16;

  initial begin
    #800000;
    if (!done) begin
      n_fail++;
      $display("FAIL watchdog expired");
      $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
      $finish;
    end
  end

  initial begin
    repeat (3) @(posedge clk);
    #1;
    // R1: reset state
    chk("R1 ok3", {31'b0, ok3}, 32'd1);
    chk("R1 bo3", {31'b0, bo3}, 32'd0);
    chk("R1 ok16", {31'b0, ok16}, 32'd1);
    @(negedge clk);
    rst_n = 1'b1;
    idle();

    for (int i = 0; i < 7; i++) begin
      logic [3:0] msg;
      logic [2:0] rm;
      logic [6:0] bad;
      msg = VEC[i][6:3];
      rm  = VEC[i][2:0];
      clear();
      shift_bits({60'b0, msg}, 4);
      emit_bits(3, 3, got);
      chk("R2 table remainder", got, {29'b0, rm});
      chk("R3 drained after emit", {31'b0, ok3}, 32'd1);
      clear();
      shift_bits({57'b0, VEC[i]}, 7);
      chk("R4 clean codeword", {31'b0, ok3}, 32'd1);
      bad = VEC[i] ^ (7'b1 << (i % 7));
      clear();
      shift_bits({57'b0, bad}, 7);
      chk("R5 single-bit error", {31'b0, ok3}, 32'd0);
    end

    // R5: every position of the 1101001 codeword
    for (int p = 0; p < 7; p++) begin
      clear();
      shift_bits({57'b0, 7'b1101001 ^ (7'b1 << p)}, 7);
      chk("R5 flip position", {31'b0, ok3}, 32'd0);
    end

    // R2: degree-4 worked division
    clear();
    shift_bits({53'b0, 11'b00111011001}, 11);
    emit_bits(4, 4, got);
    chk("R2 deg4 remainder", got, 32'hD);

    // R9: output tracks MSB and zero flag
    clear();
    step(1'b1, 1'b0, 1'b1, 1'b0);
    chk("R9 bit_out after 011", {31'b0, bo3}, 32'd0);
    chk("R9 ok after 011", {31'b0, ok3}, 32'd0);
    step(1'b1, 1'b0, 1'b1, 1'b0);
    chk("R9 bit_out after 101", {31'b0, bo3}, 32'd1);

    // R7: idle cycles with toggling inputs leave 001 intact
    clear();
    shift_bits(64'b1101, 4);
    for (int k = 0; k < 5; k++) step(k[0], ~k[0], 1'b0, 1'b0);
    emit_bits(3, 3, got);
    chk("R7 hold", got, 32'b001);

    // R8: clear wins over valid
    clear();
    shift_bits(64'b1101, 4);
    step(1'b1, 1'b0, 1'b1, 1'b1);
    chk("R8 clr priority ok3", {31'b0, ok3}, 32'd1);
    chk("R8 clr priority ok16", {31'b0, ok16}, 32'd1);

    // R6: bursts on the degree-16 copy
    clear();
    shift_bits({32'b0, 32'hA5C3_0F1E}, 32);
    emit_bits(16, 16, got);
    cw16 = {32'hA5C3_0F1E, got[15:0]};
    clear();
    shift_bits({16'b0, cw16}, 48);
    chk("R4 deg16 clean codeword", {31'b0, ok16}, 32'd1);
    for (int len = 2; len <= 16; len++) begin
      for (int off = 0; off < 3; off++) begin
        logic [47:0] e;
        int          pos;
        pos = off * 13;
        e = (48'b1 << pos) | (48'b1 << (pos + len - 1)) | (48'b1 << (pos + len / 2));
        clear();
        shift_bits({16'b0, cw16 ^ e}, 48);
        chk("R6 deg16 burst", {31'b0, ok16}, 32'd0);
      end
    end

    // R6: length-3 bursts on degree 3
    for (int p = 0; p < 5; p++) begin
      clear();
      shift_bits({57'b0, 7'b1101001 ^ (7'b101 << p)}, 7);
      chk("R6 deg3 burst", {31'b0, ok3}, 32'd0);
    end

    done = 1'b1;
    $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end

endmodule